// File: doc/BRIEF.md
# Slope-Compensated Peak Current Trip Generator

This block sits between a digital control loop and the power switches of a multi-phase peak current mode converter. For each phase it produces a falling digital reference: at the start of every switching period it loads a peak-current target and then walks it down by a fixed step on every clock. This downward slope keeps the current loop stable when the duty cycle is near one half. Each phase compares its sensed inductor current with its own reference and raises a trip that ends the high-side on-time.

A trip is only accepted once the current has stayed above the reference for a programmable number of consecutive clocks. This filters out switching noise. The period-start pulse is a one-clock strobe taken from the phase's PWM counter wrapping to zero. The target and step values on the inputs act as shadow values: they are copied into the working registers only on that strobe. Once a phase has tripped, its reference freezes and the trip stays high until the next period start. The phases share a clock and reset and are otherwise fully independent.

Top module: `slope_trip_ctrl`

## Requirements
- R1: While reset is high, every phase's reference output is 0 and every trip output is 0.
- R2: On the clock after a period-start strobe, the phase's reference output equals the target value present on its input at the strobe.
- R3: On every clock that has no strobe, while the phase has not tripped, the reference output drops by exactly the step value captured at the last strobe.
- R4: Target and step inputs that change between strobes have no effect until the next strobe.
- R5: The reference saturates at 0 and never wraps: when the step is at least the current reference, the next value is 0.
- R6: A compare hit on a clock means that the sensed current is strictly greater than the reference output. Equal values are not a hit.
- R7: Trip rises only after QUAL_CLKS consecutive clocks with a compare hit (default 4). A clock without a hit restarts the count.
- R8: Once trip is high, it stays high and the reference output stays constant until the next strobe, whatever the sensed current does.
- R9: A strobe takes priority. On the following clock, trip is low and the qualification count starts again from zero.
- R10: Each phase has its own ramp, step register, qualifier and trip. A strobe or current sample on one phase does not change another phase. Phase c uses bits [c*DW +: DW] of each bus and bit c of each per-phase vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | NUM_CH | Period-start strobe per phase (PWM counter at zero) |
| ref_i | input | NUM_CH*DW | Peak-current target per phase (shadow) |
| slope_i | input | NUM_CH*DW | Per-clock step per phase (shadow) |
| isense_i | input | NUM_CH*DW | Sensed inductor current per phase |
| ramp_o | output | NUM_CH*DW | Registered reference per phase |
| trip_o | output | NUM_CH | Registered qualified trip per phase |

## Verification
The bench targets the places where the ramp reaches the floor. A step larger than the remaining value must produce 0, and a design that wraps would show a value near full scale instead. It also drives the sensed current exactly equal to the reference, which exposes a compare that uses greater-or-equal. A noise pattern of three hits, one miss and three more hits shows whether a design forgets to restart the count and trips early. Further tests check that the reference stays frozen after a trip, that new target and step values only take effect at the strobe, and that a strobe or current on one phase leaves the other phases untouched.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int unsigned STC_DW_DEF   = 12;
  localparam int unsigned STC_QUAL_DEF = 4;

  // Ramp register action selected each clock
  typedef enum logic [1:0] {
    RAMP_RUN  = 2'd0,
    RAMP_HOLD = 2'd1,
    RAMP_LOAD = 2'd2
  } ramp_act_e;
endpackage

// File: rtl/stc_ramp.sv
module stc_ramp
  import stc_pkg::*;
#(
  parameter int unsigned DW = STC_DW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_i,
  input  logic          hold_i,
  input  logic [DW-1:0] ref_i,
  input  logic [DW-1:0] slope_i,
  output logic [DW-1:0] ramp_o
);
  logic [DW-1:0] ramp_q;
  logic [DW-1:0] step_q;
  ramp_act_e     act;

  // Strobe wins over hold; hold wins over the down-step
  always_comb begin
    if (sync_i)      act = RAMP_LOAD;
    else if (hold_i) act = RAMP_HOLD;
    else             act = RAMP_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q <= '0;
      step_q <= '0;
    end else begin
      case (act)
        RAMP_LOAD: begin
          ramp_q <= ref_i;
          step_q <= slope_i;
        end
        RAMP_HOLD: ramp_q <= ramp_q;
        default:   ramp_q <= (ramp_q > step_q) ? (ramp_q - step_q) : '0;
      endcase
    end
  end

  assign ramp_o = ramp_q;
endmodule

// File: rtl/stc_qual.sv
module stc_qual #(
  parameter int unsigned DW       = 12,
  parameter int unsigned QUAL_CLKS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_i,
  input  logic [DW-1:0] isense_i,
  input  logic [DW-1:0] ramp_i,
  output logic          trip_o
);
  localparam int unsigned CW   = (QUAL_CLKS > 1) ? $clog2(QUAL_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

  logic [CW-1:0] run_q;
  logic          trip_q;
  logic          hit;

  assign hit = (isense_i > ramp_i);

  always_ff @(posedge clk) begin
    if (rst || sync_i) begin
      run_q  <= '0;
      trip_q <= 1'b0;
    end else if (!trip_q) begin
      if (hit) begin
        if (run_q == LAST) trip_q <= 1'b1;
        else               run_q  <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  assign trip_o = trip_q;
endmodule

// File: rtl/slope_trip_ctrl.sv
module slope_trip_ctrl
  import stc_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned DW        = STC_DW_DEF,
  parameter int unsigned QUAL_CLKS = STC_QUAL_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CH-1:0]    sync_i,
  input  logic [NUM_CH*DW-1:0] ref_i,
  input  logic [NUM_CH*DW-1:0] slope_i,
  input  logic [NUM_CH*DW-1:0] isense_i,
  output logic [NUM_CH*DW-1:0] ramp_o,
  output logic [NUM_CH-1:0]    trip_o
);
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ph
      logic [DW-1:0] ramp_w;
      logic          trip_w;

      stc_ramp #(.DW(DW)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_i[c]),
        .hold_i (trip_w),
        .ref_i  (ref_i[c*DW +: DW]),
        .slope_i(slope_i[c*DW +: DW]),
        .ramp_o (ramp_w)
      );

      stc_qual #(.DW(DW), .QUAL_CLKS(QUAL_CLKS)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (sync_i[c]),
        .isense_i(isense_i[c*DW +: DW]),
        .ramp_i  (ramp_w),
        .trip_o  (trip_w)
      );

      assign ramp_o[c*DW +: DW] = ramp_w;
      assign trip_o[c]          = trip_w;
    end
  endgenerate
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned DW        = 12,
  parameter int unsigned QUAL_CLKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CH-1:0]    sync_i,
  input logic [NUM_CH*DW-1:0] ref_i,
  input logic [NUM_CH*DW-1:0] isense_i,
  input logic [NUM_CH*DW-1:0] ramp_o,
  input logic [NUM_CH-1:0]    trip_o
);
  localparam int unsigned RW = $clog2(QUAL_CLKS + 1) + 1;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ramp_o == '0 && trip_o == '0));

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chk
      logic [RW-1:0] seen_q;

      // Independent run counter of consecutive compare hits
      always_ff @(posedge clk) begin
        if (rst || sync_i[c]) seen_q <= '0;
        else if (isense_i[c*DW +: DW] > ramp_o[c*DW +: DW])
          seen_q <= (seen_q >= RW'(QUAL_CLKS)) ? seen_q : seen_q + 1'b1;
        else seen_q <= '0;
      end

      assert_sync_load_R2: assert property (@(posedge clk) disable iff (rst)
        sync_i[c] |=> ramp_o[c*DW +: DW] == $past(ref_i[c*DW +: DW]));

      assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!sync_i[c] && !trip_o[c]) |=> ramp_o[c*DW +: DW] <= $past(ramp_o[c*DW +: DW]));

      assert_trip_qualified_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_o[c]) |-> seen_q >= RW'(QUAL_CLKS));

      assert_trip_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (trip_o[c] && !sync_i[c]) |=> (trip_o[c] && $stable(ramp_o[c*DW +: DW])));

      assert_sync_clears_R9: assert property (@(posedge clk) disable iff (rst)
        sync_i[c] |=> !trip_o[c]);
    end
  endgenerate
endmodule

bind slope_trip_ctrl stc_checker #(
  .NUM_CH(NUM_CH), .DW(DW), .QUAL_CLKS(QUAL_CLKS)
) u_stc_chk (
  .clk     (clk),
  .rst     (rst),
  .sync_i  (sync_i),
  .ref_i   (ref_i),
  .isense_i(isense_i),
  .ramp_o  (ramp_o),
  .trip_o  (trip_o)
);

// File: tb/slope_trip_ctrl_tb.sv
module slope_trip_ctrl_tb;
  localparam int NUM_CH = 3;
  localparam int DW     = 12;
  localparam int QUAL   = 4;
  localparam int CLK_NS = 20;

  typedef struct packed {
    logic [11:0] r;
    logic [11:0] s;
    logic [11:0] i;
    logic [7:0]  k;
    logic [11:0] er;
    logic        et;
  } vec_t;

  localparam int NV = 11;
  // ref, step, current, clocks after strobe, expected ramp, expected trip
  localparam vec_t VECS [NV] = '{
    '{12'd2222, 12'd9,    12'd0,   8'd0,  12'd2222, 1'b0},  // R2
    '{12'd1000, 12'd10,   12'd0,   8'd5,  12'd950,  1'b0},  // R3
    '{12'd100,  12'd30,   12'd0,   8'd5,  12'd0,    1'b0},  // R5
    '{12'd500,  12'd0,    12'd500, 8'd8,  12'd500,  1'b0},  // R6
    '{12'd500,  12'd0,    12'd501, 8'd3,  12'd500,  1'b0},  // R7
    '{12'd500,  12'd0,    12'd501, 8'd4,  12'd500,  1'b1},  // R7
    '{12'd400,  12'd20,   12'd350, 8'd6,  12'd280,  1'b0},  // R3
    '{12'd400,  12'd20,   12'd350, 8'd10, 12'd260,  1'b1},  // R8
    '{12'd4095, 12'd4095, 12'd0,   8'd1,  12'd0,    1'b0},  // R5
    '{12'd5,    12'd7,    12'd0,   8'd1,  12'd0,    1'b0},  // R5
    '{12'd4095, 12'd1,    12'd0,   8'd20, 12'd4075, 1'b0}   // R3
  };

  function automatic string vreq(int n);
    case (n)
      0:       return "R2";
      2, 8, 9: return "R5";
      3:       return "R6";
      4, 5:    return "R7";
      7:       return "R8";
      default: return "R3";
    endcase
  endfunction

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NUM_CH-1:0]    sync_a = '0;
  logic [DW-1:0]        ref_a    [NUM_CH];
  logic [DW-1:0]        slope_a  [NUM_CH];
  logic [DW-1:0]        isense_a [NUM_CH];
  logic [NUM_CH*DW-1:0] ref_bus, slope_bus, isense_bus, ramp_bus;
  logic [NUM_CH-1:0]    trip_bus;
  int tests = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ref_bus[c*DW +: DW]    = ref_a[c];
      slope_bus[c*DW +: DW]  = slope_a[c];
      isense_bus[c*DW +: DW] = isense_a[c];
    end
  end

  slope_trip_ctrl #(.NUM_CH(NUM_CH), .DW(DW), .QUAL_CLKS(QUAL)) u_dut (
    .clk(clk), .rst(rst), .sync_i(sync_a), .ref_i(ref_bus),
    .slope_i(slope_bus), .isense_i(isense_bus),
    .ramp_o(ramp_bus), .trip_o(trip_bus)
  );

  function automatic logic [31:0] ramp_of(int c);
    return 32'(ramp_bus[c*DW +: DW]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_sync(int c, int r, int s, int i);
    ref_a[c] = DW'(r); slope_a[c] = DW'(s); isense_a[c] = DW'(i);
    sync_a[c] = 1'b1;
    tick();
    sync_a[c] = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) begin
      ref_a[c] = '0; slope_a[c] = '0; isense_a[c] = '0;
    end
    @(negedge clk);
    repeat (3) tick();
    chk("R1 ramp in reset", 32'(ramp_bus), 0);
    chk("R1 trip in reset", 32'(trip_bus), 0);
    rst = 1'b0;

    // Table walk on phase 0
    for (int n = 0; n < NV; n++) begin
      do_sync(0, int'(VECS[n].r), int'(VECS[n].s), int'(VECS[n].i));
      repeat (int'(VECS[n].k)) tick();
      chk({vreq(n), " ramp"}, ramp_of(0), 32'(VECS[n].er));
      chk({vreq(n), " trip"}, 32'(trip_bus[0]), 32'(VECS[n].et));
    end

    // R4: shadow values changed mid-period only apply at the next strobe
    do_sync(0, 800, 5, 0);
    ref_a[0] = 12'd100; slope_a[0] = 12'd100;
    repeat (4) tick();
    chk("R4 mid-period change ignored", ramp_of(0), 780);
    sync_a[0] = 1'b1; tick(); sync_a[0] = 1'b0;
    chk("R4 new target at strobe", ramp_of(0), 100);
    tick();
    chk("R4 new step at strobe", ramp_of(0), 0);

    // R7: a missed clock restarts qualification
    do_sync(0, 500, 0, 501);
    repeat (3) tick();
    isense_a[0] = 12'd0;
    tick();
    isense_a[0] = 12'd501;
    repeat (3) tick();
    chk("R7 restart no early trip", 32'(trip_bus[0]), 0);
    tick();
    chk("R7 trip after full run", 32'(trip_bus[0]), 1);

    // R8: trip sticky while current falls away
    isense_a[0] = 12'd0;
    repeat (3) tick();
    chk("R8 trip sticky", 32'(trip_bus[0]), 1);
    chk("R8 ramp frozen", ramp_of(0), 500);

    // R9: strobe clears trip and reloads
    do_sync(0, 600, 0, 0);
    chk("R9 trip cleared", 32'(trip_bus[0]), 0);
    chk("R9 reload", ramp_of(0), 600);

    // R10: phases independent
    do_sync(1, 300, 10, 0);
    repeat (3) tick();
    chk("R10 phase1 ramp", ramp_of(1), 270);
    chk("R10 phase0 untouched", ramp_of(0), 600);
    chk("R10 phase2 untouched", ramp_of(2), 0);
    isense_a[2] = 12'd1;
    repeat (4) tick();
    chk("R10 only phase2 trips", 32'(trip_bus), 32'b100);

    finish_run();
  end
endmodule